// File: doc/BRIEF.md
# Parallel Row-Wise Supervised Learning Controller

This block sequences supervised learning on a crossbar whose rows are trained side by side. Each row has a post-neuron comparator that reports whether the row's summed weighted current has reached its own target. Each row also has one shared gate line that the controller drives. On a start command the controller first runs an initialization phase, in which a program strobe tells the array to drive every cell to its highest conductance. It then runs learning periods. Each period is a read sub-phase followed by a write sub-phase.

On the final cycle of each read sub-phase the controller samples every row's comparator flag. A row whose flag is seen high is marked finished. That mark is sticky and is cleared only by the next start. In a write sub-phase every unfinished row gets a positive gate drive at the same time. A finished row has its gate held closed through every later read and write cycle. The rows therefore do not wait on each other, and the run lasts only as long as the slowest row.

The run ends when all rows are finished, and the done flag then rises. The run also ends if a read still finds unfinished rows after the programmed maximum number of write sub-phases, and the timeout flag then rises. The initialization, read and write lengths and the iteration limit are all counted in clock cycles. They are captured when the start command is accepted. A length of zero is treated as one cycle. All pins are plain control and status pins, because no data stream crosses this block.

Top module: `rowlearn_ctrl`

## Requirements
- R1: After reset the block is idle. All gate drive and gate close outputs, the program strobe, busy, done and timeout are 0.
- R2: A start accepted while idle or finished clears every row's finished mark, done and timeout, and latches the lengths. The program strobe is then high for exactly the initialization length in cycles, with zero counted as 1. No gate output is active during initialization.
- R3: A read sub-phase lasts the read length in cycles (zero counts as 1). Bit r of the comparator flags is sampled only on its final cycle. Values on other cycles have no effect.
- R4: A write sub-phase lasts the write length in cycles (zero counts as 1). In each of its cycles, gate drive bit r is 1 exactly for the rows not yet finished, all rows at once. Gate drive is 0 outside write sub-phases.
- R5: Once a row is finished, its gate close bit is 1 in every later read and write cycle of that run. The row receives no further gate drive.
- R6: When a read finds every row finished, the block goes to the finished state with done_o high and busy low. The number of write sub-phases equals the largest per-row need. done_o stays high until the next start.
- R7: If a read ends with some row unfinished after max_iter_i write sub-phases, the block finishes with timeout_o high and done_o low. done_o and timeout_o are never high together.
- R8: A start while busy is ignored, and the run continues unchanged.
- R9: No row ever has gate drive and gate close high in the same cycle. In the idle and finished states every gate output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a learning run (one-cycle pulse) |
| init_len_i | input | CNT_W | Initialization phase length in cycles |
| rd_len_i | input | CNT_W | Read sub-phase length in cycles |
| wr_len_i | input | CNT_W | Write sub-phase length in cycles |
| max_iter_i | input | ITER_W | Maximum number of write sub-phases |
| row_met_i | input | N_ROWS | Per-row comparator flag: target reached |
| gate_drv_o | output | N_ROWS | Per-row positive gate drive (adjust cells) |
| gate_close_o | output | N_ROWS | Per-row negative gate drive (row frozen) |
| init_pgm_o | output | 1 | Program all cells to maximum conductance |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | All rows reached their targets |
| timeout_o | output | 1 | Iteration limit exceeded |

## Verification
The bench models each row as needing a fixed number of write sub-phases. It drives the comparator flags from the gate drive it actually observes. It then checks the following:

- Per-row drive and close cycle counts, and the total run length. A controller that serialises rows would lengthen the run. A controller that forgets a finished row would over-drive it.
- Flags inverted on every read cycle except the last. A design that samples at the wrong time would freeze or keep driving the wrong rows.
- Zero lengths, an iteration limit of zero, and a timeout with a mix of finished and unfinished rows. These expose off-by-one counting.
- A start pulse in mid-run. A design that restarted on it would change the run length.

// File: rtl/rowlearn_pkg.sv
package rowlearn_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INIT,
    PH_READ,
    PH_WRITE,
    PH_FINISH
  } phase_t;
endpackage

// File: rtl/rowlearn_seq.sv
module rowlearn_seq
  import rowlearn_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  init_len_i,
  input  logic [CNT_W-1:0]  rd_len_i,
  input  logic [CNT_W-1:0]  wr_len_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic              all_met_i,
  output phase_t            phase_o,
  output logic              clr_o,
  output logic              sample_o,
  output logic              timeout_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q, init_len_q, rd_len_q, wr_len_q, cur_len;
  logic [ITER_W-1:0] iter_q, max_iter_q;
  logic              to_q, accept, last;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign accept = start_i && (phase_q == PH_IDLE || phase_q == PH_FINISH);

  always_comb begin
    case (phase_q)
      PH_INIT:  cur_len = init_len_q;
      PH_READ:  cur_len = rd_len_q;
      PH_WRITE: cur_len = wr_len_q;
      default:  cur_len = ONE;
    endcase
  end

  assign last = (cnt_q == cur_len - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      iter_q     <= '0;
      to_q       <= 1'b0;
      init_len_q <= ONE;
      rd_len_q   <= ONE;
      wr_len_q   <= ONE;
      max_iter_q <= '0;
    end else if (accept) begin
      phase_q    <= PH_INIT;
      cnt_q      <= '0;
      iter_q     <= '0;
      to_q       <= 1'b0;
      init_len_q <= at_least_one(init_len_i);
      rd_len_q   <= at_least_one(rd_len_i);
      wr_len_q   <= at_least_one(wr_len_i);
      max_iter_q <= max_iter_i;
    end else begin
      case (phase_q)
        PH_INIT: begin
          cnt_q <= last ? '0 : cnt_q + ONE;
          if (last) phase_q <= PH_READ;
        end
        PH_READ: begin
          cnt_q <= last ? '0 : cnt_q + ONE;
          if (last) begin
            if (all_met_i) begin
              phase_q <= PH_FINISH;
            end else if (iter_q == max_iter_q) begin
              phase_q <= PH_FINISH;
              to_q    <= 1'b1;
            end else begin
              phase_q <= PH_WRITE;
            end
          end
        end
        PH_WRITE: begin
          cnt_q <= last ? '0 : cnt_q + ONE;
          if (last) begin
            phase_q <= PH_READ;
            iter_q  <= iter_q + ITER_W'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign clr_o     = accept;
  assign sample_o  = (phase_q == PH_READ) && last;
  assign timeout_o = to_q;

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WRITE) |-> (iter_q < max_iter_q)); // R7
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INIT || phase_q == PH_READ || phase_q == PH_WRITE) |-> (cnt_q < cur_len)); // R4
  AST_FINISH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FINISH && !start_i) |=> (phase_q == PH_FINISH)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ && !last) |=> (phase_q == PH_READ)); // R8
endmodule

// File: rtl/rowlearn_rows.sv
module rowlearn_rows #(
  parameter int N_ROWS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              wr_phase_i,
  input  logic              learn_phase_i,
  input  logic [N_ROWS-1:0] met_i,
  output logic              all_met_o,
  output logic [N_ROWS-1:0] gate_drv_o,
  output logic [N_ROWS-1:0] gate_close_o
);
  logic [N_ROWS-1:0] fin_q, fin_next;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign fin_next[r] = fin_q[r] | (sample_i & met_i[r]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fin_q[r] <= 1'b0;
      else if (clr_i)  fin_q[r] <= 1'b0;
      else             fin_q[r] <= fin_next[r];
    end

    assign gate_drv_o[r]   = wr_phase_i & ~fin_q[r];
    assign gate_close_o[r] = learn_phase_i & fin_q[r];

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_drv_o[r] && gate_close_o[r])); // R9
    AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_q[r] && !clr_i) |=> fin_q[r]); // R5
  end

  assign all_met_o = &fin_next;
endmodule

// File: rtl/rowlearn_ctrl.sv
module rowlearn_ctrl
  import rowlearn_pkg::*;
#(
  parameter int N_ROWS = 4,
  parameter int CNT_W  = 16,
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  init_len_i,
  input  logic [CNT_W-1:0]  rd_len_i,
  input  logic [CNT_W-1:0]  wr_len_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic [N_ROWS-1:0] row_met_i,
  output logic [N_ROWS-1:0] gate_drv_o,
  output logic [N_ROWS-1:0] gate_close_o,
  output logic              init_pgm_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  phase_t phase;
  logic   clr, sample, all_met, to_flag, wr_phase, learn_phase;

  rowlearn_seq #(.CNT_W(CNT_W), .ITER_W(ITER_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .init_len_i (init_len_i),
    .rd_len_i   (rd_len_i),
    .wr_len_i   (wr_len_i),
    .max_iter_i (max_iter_i),
    .all_met_i  (all_met),
    .phase_o    (phase),
    .clr_o      (clr),
    .sample_o   (sample),
    .timeout_o  (to_flag)
  );

  assign wr_phase    = (phase == PH_WRITE);
  assign learn_phase = (phase == PH_READ) || (phase == PH_WRITE);

  rowlearn_rows #(.N_ROWS(N_ROWS)) u_rows (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (clr),
    .sample_i      (sample),
    .wr_phase_i    (wr_phase),
    .learn_phase_i (learn_phase),
    .met_i         (row_met_i),
    .all_met_o     (all_met),
    .gate_drv_o    (gate_drv_o),
    .gate_close_o  (gate_close_o)
  );

  assign init_pgm_o = (phase == PH_INIT);
  assign busy_o     = learn_phase || init_pgm_o;
  assign done_o     = (phase == PH_FINISH) && !to_flag;
  assign timeout_o  = (phase == PH_FINISH) && to_flag;

  AST_DONE_TO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o)); // R7
  AST_INIT_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    init_pgm_o |-> (gate_drv_o == '0 && gate_close_o == '0)); // R2
  AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (gate_drv_o == '0 && gate_close_o == '0)); // R9
endmodule

// File: tb/rowlearn_ctrl_tb.sv
module rowlearn_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CW = 16;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] init_len_i = '0, rd_len_i = '0, wr_len_i = '0;
  logic [IW-1:0] max_iter_i = '0;
  logic [N-1:0]  row_met_i = '0;
  logic [N-1:0]  gate_drv_o, gate_close_o;
  logic          init_pgm_o, busy_o, done_o, timeout_o;

  int checks = 0;
  int errors = 0;

  rowlearn_ctrl #(.N_ROWS(N), .CNT_W(CW), .ITER_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .init_len_i(init_len_i), .rd_len_i(rd_len_i), .wr_len_i(wr_len_i),
    .max_iter_i(max_iter_i), .row_met_i(row_met_i),
    .gate_drv_o(gate_drv_o), .gate_close_o(gate_close_o),
    .init_pgm_o(init_pgm_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(gate_drv_o == 0 && gate_close_o == 0, "R1", "gates after reset",
          int'({gate_drv_o, gate_close_o}), 0);
    check({init_pgm_o, busy_o, done_o, timeout_o} == 0, "R1", "status after reset",
          int'({init_pgm_o, busy_o, done_o, timeout_o}), 0);
  endtask

  task automatic run_case(input string tag, input int il, input int rl, input int wl,
                          input int mi, input int n0, input int n1, input int n2,
                          input int n3, input bit glitch, input int ign_at);
    int need[N];
    int drv_cnt[N];
    int close_cnt[N];
    int il0, rl0, wl0, w_exp, max_need, exp_busy, k, init_cnt, bad_pos, bad_excl;
    bit exp_done;
    need = '{n0, n1, n2, n3};
    il0 = (il == 0) ? 1 : il;
    rl0 = (rl == 0) ? 1 : rl;
    wl0 = (wl == 0) ? 1 : wl;
    max_need = 0;
    for (int r = 0; r < N; r++) begin
      drv_cnt[r] = 0;
      close_cnt[r] = 0;
      if (need[r] > max_need) max_need = need[r];
    end
    exp_done = (max_need <= mi);
    w_exp = exp_done ? max_need : mi;
    exp_busy = il0 + (w_exp + 1) * rl0 + w_exp * wl0;
    init_cnt = 0; bad_pos = 0; bad_excl = 0;

    @(negedge clk);
    init_len_i = CW'(il); rd_len_i = CW'(rl); wr_len_i = CW'(wl);
    max_iter_i = IW'(mi);
    start_i = 1'b1;
    k = 0;
    forever begin
      @(negedge clk);
      start_i = (k == ign_at);
      if (k == 0)
        check(!done_o && !timeout_o, "R2", {tag, " flags cleared by start"},
              int'({done_o, timeout_o}), 0);
      if (!busy_o || k > 20000) break;
      begin
        int j;
        bit is_wr, is_last_rd;
        j = (k >= il0) ? (k - il0) % (rl0 + wl0) : -1;
        is_wr = (j >= rl0);
        is_last_rd = (j == rl0 - 1);
        if (init_pgm_o) init_cnt++;
        if (init_pgm_o != (k < il0)) bad_pos++;
        for (int r = 0; r < N; r++) begin
          bit m;
          if (gate_drv_o[r] && !is_wr) bad_pos++;
          if (gate_drv_o[r] && gate_close_o[r]) bad_excl++;
          if (gate_drv_o[r]) drv_cnt[r]++;
          if (gate_close_o[r]) close_cnt[r]++;
          m = (drv_cnt[r] >= need[r] * wl0);
          row_met_i[r] = (glitch && !is_last_rd) ? !m : m;
        end
      end
      k++;
    end
    start_i = 1'b0;
    check(init_cnt == il0, "R2", {tag, " init strobe cycles"}, init_cnt, il0);
    check(bad_pos == 0, "R4", {tag, " strobe/drive outside own phase"}, bad_pos, 0);
    check(bad_excl == 0, "R9", {tag, " drive and close together"}, bad_excl, 0);
    check(k == exp_busy, (ign_at >= 0) ? "R8" : "R6", {tag, " run length"}, k, exp_busy);
    check(done_o == exp_done, "R6", {tag, " done flag"}, int'(done_o), int'(exp_done));
    check(timeout_o == !exp_done, "R7", {tag, " timeout flag"}, int'(timeout_o), int'(!exp_done));
    for (int r = 0; r < N; r++) begin
      int e_drv, e_close, lim;
      lim = (need[r] < w_exp) ? need[r] : w_exp;
      e_drv = lim * wl0;
      e_close = (need[r] <= w_exp) ? exp_busy - (il0 + (need[r] + 1) * rl0 + need[r] * wl0) : 0;
      check(drv_cnt[r] == e_drv, glitch ? "R3" : "R4", $sformatf("%s row%0d drive cycles", tag, r),
            drv_cnt[r], e_drv);
      check(close_cnt[r] == e_close, "R5", $sformatf("%s row%0d close cycles", tag, r),
            close_cnt[r], e_close);
    end
    repeat (3) @(negedge clk);
    check(gate_drv_o == 0 && gate_close_o == 0 && !busy_o, "R9", {tag, " gates idle after finish"},
          int'({gate_drv_o, gate_close_o}), 0);
    check(done_o == exp_done, "R6", {tag, " done held"}, int'(done_o), int'(exp_done));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    run_case("basic",      3, 2, 2, 10, 3, 1, 4, 2, 1'b0, -1);
    run_case("all_met",    2, 2, 3, 10, 0, 0, 0, 0, 1'b0, -1);
    run_case("timeout",    2, 1, 2,  2, 1, 5, 2, 0, 1'b0, -1);
    run_case("zero_len",   0, 0, 0,  5, 2, 0, 1, 3, 1'b0, -1);
    run_case("r3_glitch",  2, 3, 1,  8, 2, 2, 3, 1, 1'b1, -1);
    run_case("r8_restart", 3, 2, 2, 10, 3, 1, 4, 2, 1'b0,  5);
    run_case("limit_zero", 1, 2, 2,  0, 1, 0, 0, 0, 1'b0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule